// File: doc/BRIEF.md
# Display Video Timing Generator

The block produces horizontal sync, vertical sync, display enable and an active-window flag for a video output. It runs on the pixel clock. Software sets it up through a small register bank with a single write port and a combinational read port. All vertical quantities are absolute pixel-clock offsets from the start of the frame, not line numbers. Because of this, a horizontal skew can be folded into the vertical window bounds.

Inside the display window, an optional active window marks where real image data lies. Pixels inside it pass straight through from the input. Display pixels outside it take a programmed border colour. The engine also keeps a line counter and a frame counter that software can read, and it applies a programmable inversion to each sync output.

All registers except the enable go through a shadow stage. A mode change applied mid-frame takes effect only at the next frame boundary.

Top module: `video_timing_gen`

## Requirements
- R1: The register at word address 2 holds the line length in pixel clocks in bits 31:16 and the hsync width in bits 15:0. While running, the raw hsync is high during the first width clocks of each line, and each line lasts exactly the line length.
- R2: The register at address 3 holds the frame length in pixel clocks, and the register at address 4 holds the vsync width in pixel clocks. The frame position runs from 0 to length−1 and then wraps, and raw vsync is high while the position is below the width.
- R3: Raw display enable is high when the horizontal position lies within the inclusive window at address 5 (end in bits 31:16, start in bits 15:0) and the frame position lies within the inclusive range from address 6 (start) to address 7 (end).
- R4: The active window applies its horizontal limits (address 8, packed like address 5) only when bit 29 of the config register (address 1) is set. It applies its vertical limits (addresses 9 and 10) only when bit 30 is set. active_o is high only inside the display window and inside every enabled limit.
- R5: pixel_o equals pix_i when active_o is high. It equals the low bits of the border colour register (address 11) within the display window outside the active window, and it is zero outside the display window.
- R6: The register at address 12 inverts hsync_o with bit 0, vsync_o with bit 1 and de_o with bit 2.
- R7: Bit 0 of address 0 starts the engine when written as 1 and stops it when written as 0. While the engine is stopped, the raw syncs and display enable are low, active_o is low, and both counters read as 0. A start begins at frame position 0 in the following cycle.
- R8: Reading address 14 returns the line counter. It increments at the end of each line and clears at the start of each frame.
- R9: Reading address 13 returns the frame counter. It increments at each frame wrap.
- R10: A write to any of addresses 1 to 12 changes the generated timing only at the next frame boundary, or in the next cycle if the engine is stopped. Reading those addresses returns the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read word address |
| rd_data_o | output | 32 | Register read data, combinational |
| pix_i | input | PIX_W | Incoming image pixel |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Display enable after polarity |
| active_o | output | 1 | Inside the active image window |
| pixel_o | output | PIX_W | Output pixel with border fill |

## Verification
The assertions check several properties on every cycle:
- the horizontal and frame positions stay below their programmed periods;
- vsync is asserted at frame position 0;
- active_o implies display enable;
- border fill is driven outside the active window;
- the outputs are idle and the counters are zero while the engine is stopped;
- the line counter clears and the frame counter steps at each wrap;
- the live timing set holds still between frame boundaries.

The exact pulse widths, window edges, skewed vertical bounds, polarity inversion and the point at which a mid-frame reprogramming takes hold are shown only by the bench scenarios. In those scenarios a behavioural model tracks three different modes cycle by cycle.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned FIELD_W = 16;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned CFG_HACT_BIT = 29;
  localparam int unsigned CFG_VACT_BIT = 30;

  typedef enum logic [ADDR_W-1:0] {
    A_ENABLE   = 4'd0,
    A_CONFIG   = 4'd1,
    A_HCTL     = 4'd2,
    A_VPERIOD  = 4'd3,
    A_VPULSE   = 4'd4,
    A_DHCTL    = 4'd5,
    A_DVSTART  = 4'd6,
    A_DVEND    = 4'd7,
    A_AHCTL    = 4'd8,
    A_AVSTART  = 4'd9,
    A_AVEND    = 4'd10,
    A_BORDER   = 4'd11,
    A_POLARITY = 4'd12,
    A_FRAMECNT = 4'd13,
    A_LINECNT  = 4'd14
  } vtg_addr_e;

  typedef struct packed {
    logic [REG_W-1:0] cfg;
    logic [REG_W-1:0] hctl;
    logic [REG_W-1:0] vperiod;
    logic [REG_W-1:0] vpulse;
    logic [REG_W-1:0] dhctl;
    logic [REG_W-1:0] dvstart;
    logic [REG_W-1:0] dvend;
    logic [REG_W-1:0] ahctl;
    logic [REG_W-1:0] avstart;
    logic [REG_W-1:0] avend;
    logic [REG_W-1:0] border;
    logic [REG_W-1:0] pol;
  } vtg_cfg_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              frame_end_i,
  output logic              en_o,
  output vtg_cfg_t          shadow_o,
  output vtg_cfg_t          live_o
);
  logic     en_q;
  vtg_cfg_t shadow_q, live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      shadow_q <= '0;
      live_q   <= '0;
    end else begin
      // live set follows shadow only between frames
      if (!en_q || frame_end_i) live_q <= shadow_q;
      if (wr_en_i) begin
        case (vtg_addr_e'(wr_addr_i))
          A_ENABLE:   en_q             <= wr_data_i[0];
          A_CONFIG:   shadow_q.cfg     <= wr_data_i;
          A_HCTL:     shadow_q.hctl    <= wr_data_i;
          A_VPERIOD:  shadow_q.vperiod <= wr_data_i;
          A_VPULSE:   shadow_q.vpulse  <= wr_data_i;
          A_DHCTL:    shadow_q.dhctl   <= wr_data_i;
          A_DVSTART:  shadow_q.dvstart <= wr_data_i;
          A_DVEND:    shadow_q.dvend   <= wr_data_i;
          A_AHCTL:    shadow_q.ahctl   <= wr_data_i;
          A_AVSTART:  shadow_q.avstart <= wr_data_i;
          A_AVEND:    shadow_q.avend   <= wr_data_i;
          A_BORDER:   shadow_q.border  <= wr_data_i;
          A_POLARITY: shadow_q.pol     <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  assign en_o     = en_q;
  assign shadow_o = shadow_q;
  assign live_o   = live_q;
endmodule

// File: rtl/vtg_counters.sv
module vtg_counters
  import vtg_pkg::*;
#(
  parameter int unsigned LINE_W  = 16,
  parameter int unsigned FRAME_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [FIELD_W-1:0] hperiod_i,
  input  logic [REG_W-1:0]   vperiod_i,
  output logic [REG_W-1:0]   pos_o,
  output logic [FIELD_W-1:0] hpos_o,
  output logic [LINE_W-1:0]  line_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               frame_end_o
);
  logic [REG_W-1:0]   pos_q;
  logic [FIELD_W-1:0] hpos_q;
  logic [LINE_W-1:0]  line_q;
  logic [FRAME_W-1:0] frame_q;
  logic [REG_W:0]     pos_inc;
  logic [FIELD_W:0]   hpos_inc;
  logic               line_end;

  assign pos_inc     = {1'b0, pos_q} + 1'b1;
  assign hpos_inc    = {1'b0, hpos_q} + 1'b1;
  // >= keeps a zero period from running away
  assign frame_end_o = en_i && (pos_inc >= {1'b0, vperiod_i});
  assign line_end    = hpos_inc >= {1'b0, hperiod_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      hpos_q  <= '0;
      line_q  <= '0;
      frame_q <= '0;
    end else if (!en_i) begin
      pos_q   <= '0;
      hpos_q  <= '0;
      line_q  <= '0;
      frame_q <= '0;
    end else if (frame_end_o) begin
      pos_q   <= '0;
      hpos_q  <= '0;
      line_q  <= '0;
      frame_q <= frame_q + 1'b1;
    end else begin
      pos_q <= pos_inc[REG_W-1:0];
      if (line_end) begin
        hpos_q <= '0;
        line_q <= line_q + 1'b1;
      end else begin
        hpos_q <= hpos_inc[FIELD_W-1:0];
      end
    end
  end

  assign pos_o   = pos_q;
  assign hpos_o  = hpos_q;
  assign line_o  = line_q;
  assign frame_o = frame_q;
endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
  import vtg_pkg::*;
#(
  parameter int unsigned PIX_W = 24
) (
  input  logic               en_i,
  input  logic [REG_W-1:0]   pos_i,
  input  logic [FIELD_W-1:0] hpos_i,
  input  vtg_cfg_t           live_i,
  input  logic [PIX_W-1:0]   pix_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic               active_o,
  output logic [PIX_W-1:0]   pixel_o
);
  logic hs_raw, vs_raw, de_raw;
  logic in_dh, in_dv, in_ah, in_av;
  logic [2:0] raw_vec, pol_vec, out_vec;

  function automatic logic in_span(input logic [REG_W-1:0] v,
                                   input logic [REG_W-1:0] lo,
                                   input logic [REG_W-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  always_comb begin
    hs_raw = en_i && (hpos_i < live_i.hctl[FIELD_W-1:0]);
    vs_raw = en_i && (pos_i < live_i.vpulse);
    in_dh  = in_span(REG_W'(hpos_i), REG_W'(live_i.dhctl[FIELD_W-1:0]),
                     REG_W'(live_i.dhctl[REG_W-1:FIELD_W]));
    in_dv  = in_span(pos_i, live_i.dvstart, live_i.dvend);
    in_ah  = !live_i.cfg[CFG_HACT_BIT] ||
             in_span(REG_W'(hpos_i), REG_W'(live_i.ahctl[FIELD_W-1:0]),
                     REG_W'(live_i.ahctl[REG_W-1:FIELD_W]));
    in_av  = !live_i.cfg[CFG_VACT_BIT] ||
             in_span(pos_i, live_i.avstart, live_i.avend);
    de_raw   = en_i && in_dh && in_dv;
    active_o = de_raw && in_ah && in_av;
    if (active_o)    pixel_o = pix_i;
    else if (de_raw) pixel_o = live_i.border[PIX_W-1:0];
    else             pixel_o = '0;
  end

  assign raw_vec = {de_raw, vs_raw, hs_raw};
  assign pol_vec = live_i.pol[2:0];

  for (genvar g = 0; g < 3; g++) begin : g_pol
    assign out_vec[g] = raw_vec[g] ^ pol_vec[g];
  end

  assign hsync_o = out_vec[0];
  assign vsync_o = out_vec[1];
  assign de_o    = out_vec[2];
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vtg_pkg::*;
#(
  parameter int unsigned PIX_W   = 24,
  parameter int unsigned LINE_W  = 16,
  parameter int unsigned FRAME_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [3:0]        rd_addr_i,
  output logic [31:0]       rd_data_o,
  input  logic [PIX_W-1:0]  pix_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              active_o,
  output logic [PIX_W-1:0]  pixel_o
);
  logic               en_q;
  logic               frame_end;
  vtg_cfg_t           shadow_cfg, live_cfg;
  logic [REG_W-1:0]   pos_q;
  logic [FIELD_W-1:0] hpos_q;
  logic [LINE_W-1:0]  line_q;
  logic [FRAME_W-1:0] frame_q;

  vtg_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .frame_end_i (frame_end),
    .en_o        (en_q),
    .shadow_o    (shadow_cfg),
    .live_o      (live_cfg)
  );

  vtg_counters #(.LINE_W(LINE_W), .FRAME_W(FRAME_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_q),
    .hperiod_i   (live_cfg.hctl[REG_W-1:FIELD_W]),
    .vperiod_i   (live_cfg.vperiod),
    .pos_o       (pos_q),
    .hpos_o      (hpos_q),
    .line_o      (line_q),
    .frame_o     (frame_q),
    .frame_end_o (frame_end)
  );

  vtg_decode #(.PIX_W(PIX_W)) u_dec (
    .en_i     (en_q),
    .pos_i    (pos_q),
    .hpos_i   (hpos_q),
    .live_i   (live_cfg),
    .pix_i    (pix_i),
    .hsync_o  (hsync_o),
    .vsync_o  (vsync_o),
    .de_o     (de_o),
    .active_o (active_o),
    .pixel_o  (pixel_o)
  );

  // counters are gated so a just-stopped engine never reads stale counts
  always_comb begin
    case (vtg_addr_e'(rd_addr_i))
      A_ENABLE:   rd_data_o = {{(REG_W-1){1'b0}}, en_q};
      A_CONFIG:   rd_data_o = shadow_cfg.cfg;
      A_HCTL:     rd_data_o = shadow_cfg.hctl;
      A_VPERIOD:  rd_data_o = shadow_cfg.vperiod;
      A_VPULSE:   rd_data_o = shadow_cfg.vpulse;
      A_DHCTL:    rd_data_o = shadow_cfg.dhctl;
      A_DVSTART:  rd_data_o = shadow_cfg.dvstart;
      A_DVEND:    rd_data_o = shadow_cfg.dvend;
      A_AHCTL:    rd_data_o = shadow_cfg.ahctl;
      A_AVSTART:  rd_data_o = shadow_cfg.avstart;
      A_AVEND:    rd_data_o = shadow_cfg.avend;
      A_BORDER:   rd_data_o = shadow_cfg.border;
      A_POLARITY: rd_data_o = shadow_cfg.pol;
      A_FRAMECNT: rd_data_o = en_q ? REG_W'(frame_q) : '0;
      A_LINECNT:  rd_data_o = en_q ? REG_W'(line_q) : '0;
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
  import vtg_pkg::*;
#(
  parameter int unsigned PIX_W   = 24,
  parameter int unsigned LINE_W  = 16,
  parameter int unsigned FRAME_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_q,
  input logic               frame_end,
  input vtg_cfg_t           live_cfg,
  input logic [REG_W-1:0]   pos_q,
  input logic [FIELD_W-1:0] hpos_q,
  input logic [LINE_W-1:0]  line_q,
  input logic [FRAME_W-1:0] frame_q,
  input logic               hsync_o,
  input logic               vsync_o,
  input logic               de_o,
  input logic               active_o,
  input logic [PIX_W-1:0]   pixel_o
);
  assert_hpos_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && live_cfg.hctl[REG_W-1:FIELD_W] != '0) |->
      (hpos_q < live_cfg.hctl[REG_W-1:FIELD_W]));

  assert_pos_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && live_cfg.vperiod != '0) |-> (pos_q < live_cfg.vperiod));

  assert_vsync_at_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && pos_q == '0 && live_cfg.vpulse != '0) |-> (vsync_o != live_cfg.pol[1]));

  assert_active_in_display_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (de_o ^ live_cfg.pol[2]));

  assert_border_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((de_o ^ live_cfg.pol[2]) && !active_o) |-> (pixel_o == live_cfg.border[PIX_W-1:0]));

  assert_idle_outputs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (hsync_o == live_cfg.pol[0] && vsync_o == live_cfg.pol[1] &&
               de_o == live_cfg.pol[2] && !active_o));

  assert_counts_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !$past(en_q)) |-> (line_q == '0 && frame_q == '0));

  assert_line_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_end) |-> (line_q == '0 && pos_q == '0));

  assert_frame_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && $past(frame_end)) |-> (frame_q == $past(frame_q) + 1'b1));

  assert_live_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_q && !frame_end) |-> $stable(live_cfg));
endmodule

bind video_timing_gen vtg_checker #(
  .PIX_W(PIX_W), .LINE_W(LINE_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_q      (en_q),
  .frame_end (frame_end),
  .live_cfg  (live_cfg),
  .pos_q     (pos_q),
  .hpos_q    (hpos_q),
  .line_q    (line_q),
  .frame_q   (frame_q),
  .hsync_o   (hsync_o),
  .vsync_o   (vsync_o),
  .de_o      (de_o),
  .active_o  (active_o),
  .pixel_o   (pixel_o)
);

// File: tb/video_timing_gen_tb.sv
module video_timing_gen_tb;
  localparam int PIX_W = 24;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [3:0]       wr_addr = '0;
  logic [31:0]      wr_data = '0;
  logic [3:0]       rd_addr = 4'd14;
  logic [31:0]      rd_data;
  logic [PIX_W-1:0] pix = 24'h000001;
  logic             hsync, vsync, de, active;
  logic [PIX_W-1:0] pixel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  video_timing_gen #(.PIX_W(PIX_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pix_i(pix), .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
    .active_o(active), .pixel_o(pixel)
  );

  always @(posedge clk) pix <= pix + 24'h010203;

  // behavioural reference: one frame position, everything else derived
  logic [31:0] m_sh [16];
  logic [31:0] m_lv [16];
  bit          m_en;
  longint      m_pos, m_frame;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_sh[i] = '0; m_lv[i] = '0; end
      m_en = 0; m_pos = 0; m_frame = 0;
    end else begin
      if (!m_en) begin
        for (int i = 0; i < 16; i++) m_lv[i] = m_sh[i];
        m_pos = 0; m_frame = 0;
      end else if (m_pos + 1 >= longint'(m_lv[3])) begin
        for (int i = 0; i < 16; i++) m_lv[i] = m_sh[i];
        m_pos = 0; m_frame = m_frame + 1;
      end else begin
        m_pos = m_pos + 1;
      end
      if (wr_en) begin
        if (wr_addr == 4'd0) m_en = wr_data[0];
        else if (wr_addr <= 4'd12) m_sh[wr_addr] = wr_data;
      end
    end
  end

  function automatic bit in_rng(longint v, longint lo, longint hi);
    return v >= lo && v <= hi;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      longint hp, hper, line;
      bit hs, vs, dd, ah, av, ac;
      longint px, rd;
      hper = longint'(m_lv[2][31:16]);
      hp   = (hper == 0) ? 0 : m_pos % hper;
      line = (hper == 0) ? 0 : m_pos / hper;
      hs = m_en && hp < longint'(m_lv[2][15:0]);
      vs = m_en && m_pos < longint'(m_lv[4]);
      dd = m_en && in_rng(hp, m_lv[5][15:0], m_lv[5][31:16]) &&
           in_rng(m_pos, m_lv[6], m_lv[7]);
      ah = !m_lv[1][29] || in_rng(hp, m_lv[8][15:0], m_lv[8][31:16]);
      av = !m_lv[1][30] || in_rng(m_pos, m_lv[9], m_lv[10]);
      ac = dd && ah && av;
      px = ac ? longint'(pix) : dd ? longint'(m_lv[11][PIX_W-1:0]) : 0;
      chk("R1 R6 R10 hsync",  hsync,  hs ^ m_lv[12][0]);
      chk("R2 R6 R10 vsync",  vsync,  vs ^ m_lv[12][1]);
      chk("R3 R6 R10 de",     de,     dd ^ m_lv[12][2]);
      chk("R4 active",        active, ac);
      chk("R5 pixel",         pixel,  px);
      if (rd_addr == 4'd14)      begin rd = m_en ? line : 0;    chk("R8 line count", rd_data, rd); end
      else if (rd_addr == 4'd13) begin rd = m_en ? m_frame : 0; chk("R9 frame count", rd_data, rd); end
      else if (rd_addr == 4'd0)  chk("R7 enable readback", rd_data, longint'(m_en));
      else                       chk("R10 shadow readback", rd_data, longint'(m_sh[rd_addr]));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;   // R7: idle state checked on every clock before start
    idle(2);
    // mode A: 15-clock lines, 8 lines per frame
    wr(4'd2, {16'd15, 16'd2});
    wr(4'd3, 32'd120);
    wr(4'd4, 32'd15);
    wr(4'd5, {16'd12, 16'd5});
    wr(4'd6, 32'd45);
    wr(4'd7, 32'd104);
    wr(4'd11, 32'h00ABCDEF);
    rd_addr = 4'd2;
    idle(3);
    rd_addr = 4'd14;
    wr(4'd0, 32'd1);
    idle(300);
    // border window written mid-frame
    rd_addr = 4'd13;
    wr(4'd8, {16'd10, 16'd6});
    wr(4'd9, 32'd45);
    wr(4'd10, 32'd89);
    wr(4'd1, 32'h6000_0000);
    idle(260);
    // mode B: skewed vertical window, all polarities inverted
    rd_addr = 4'd14;
    wr(4'd1, 32'h2000_0000);
    wr(4'd8, {16'd4, 16'd3});
    wr(4'd2, {16'd7, 16'd1});
    wr(4'd3, 32'd42);
    wr(4'd4, 32'd7);
    wr(4'd5, {16'd5, 16'd2});
    wr(4'd6, 32'd16);
    wr(4'd7, 32'd36);
    wr(4'd12, 32'd7);
    idle(250);
    // stop, then restart
    wr(4'd0, 32'd0);
    rd_addr = 4'd13;
    idle(10);
    rd_addr = 4'd0;
    idle(3);
    rd_addr = 4'd14;
    wr(4'd0, 32'd1);
    idle(100);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end
endmodule